// File: doc/BRIEF.md
# Branch-Record Source Address Injection Register with Privilege Gate

This block holds one 64-bit register into which privileged software writes the source address of a branch record that is to be injected. Each read or write request is checked, in the same cycle, against a fixed-priority chain of conditions. The chain uses the requester's privilege level, which higher levels are implemented, the security state, a 2-bit secure-debug enable field and a set of fine-grained trap controls. The result is one of three outcomes: the access completes, it is treated as undefined, or it traps to privilege level 2 or 3 with a fixed syndrome class.

A write that completes is stored at the next rising clock edge. The stored value is canonicalised first: when the address bits at and above a split point `P` are not uniform, those upper bits are replaced by a fixed pattern that is neither all zeros nor all ones. A read returns the stored value on `rd_data`, which always shows the register contents. An access that does not complete leaves the register untouched.

Top module: `brsrc_gate`

## Requirements
- R1: Any request made at privilege level 0 (`cur_lvl` = 0) reports undefined, whether it is a read or a write.
- R2: Any request made at privilege level 3 completes, whatever the other control inputs are.
- R3: At levels 1 and 2, when level 3 is implemented and `undef_first` is 1, the request is undefined if the enable field is "blocked". In secure state (`non_secure` = 0), blocked means `sdbg_en` is not 2'b11. In non-secure state, blocked means `sdbg_en[0]` is 0. This check takes priority over every trap. Without level 3, nothing is blocked.
- R4: At level 1 only, when R3 has not fired, the request traps to level 2 under these conditions: `lvl2_enabled` is 1, `fgt_present` is 1, level 3 is either absent or has `fgt_lvl3_en` = 1, and the trap bit for the request's direction is 0. This trap outranks the blocked-field handling of R6.
- R5: A request at level 2 never traps to level 2.
- R6: At levels 1 and 2, when R3 and R4 have not fired and the enable field is blocked (with level 3 present), the request is undefined if `undef_sel` is 1. Otherwise it traps to level 3. In all remaining cases the request completes.
- R7: `result` encodes 2'b00 for completed, 2'b01 for undefined and 2'b10 for trap. On a trap, `trap_lvl` is 2 or 3 and `syndrome` is 6'h18. Otherwise both are zero, and they are also zero when no request is presented.
- R8: Reads test only `fgt_rd_n`, and writes test only `fgt_wr_n`. Apart from that bit, reads and writes follow the same chain.
- R9: A completed write whose bits [63:P] are all zeros or all ones stores the full 64-bit value unchanged.
- R10: A completed write whose bits [63:P] are mixed stores bits [P-1:0] as written. It sets bit 63 to 1 and clears bits [62:P].
- R11: Synchronous active-low reset clears the register to zero. A write that is undefined or trapped leaves the register unchanged.
- R12: `rd_data` shows the register contents at all times. A completed write becomes visible on `rd_data` right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | A read or write request is presented this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| cur_lvl | input | 2 | Privilege level of the requester (0..3) |
| lvl3_present | input | 1 | Privilege level 3 is implemented |
| lvl2_enabled | input | 1 | Privilege level 2 is enabled in the current state |
| non_secure | input | 1 | Security state: 1 = non-secure |
| sdbg_en | input | 2 | Secure-debug enable field |
| fgt_present | input | 1 | Fine-grained traps are implemented |
| fgt_lvl3_en | input | 1 | Level-3 enable for fine-grained traps |
| fgt_rd_n | input | 1 | Read fine-grained control, 0 = trap reads |
| fgt_wr_n | input | 1 | Write fine-grained control, 0 = trap writes |
| undef_first | input | 1 | The early undefined check of R3 is active |
| undef_sel | input | 1 | Blocked requests become undefined instead of trapping to level 3 |
| rd_data | output | 64 | Register contents |
| result | output | 2 | Outcome code of the presented request |
| trap_lvl | output | 2 | Target level of a trap, 0 otherwise |
| syndrome | output | 6 | Syndrome class of a trap, 0 otherwise |

## Verification
The bench builds the block with the default split point P = 56, which leaves an 8-bit upper field. With that value a realistic user-space address such as 0x0000_1234_5678_9ABC is canonical. Values whose upper byte mixes ones and zeros (0x12..., 0x7F...) are not, so the replacement pattern 0x80 can be told apart from both the written byte and either uniform value. The field is also wide enough that a sign-extended negative address (0xFF80...) shows the all-ones case.

// File: rtl/brsrc_pkg.sv
// Package: shared encodings for the branch-record source register gate.
// Assumes nothing beyond a 2-bit privilege level and a 6-bit syndrome.
package brsrc_pkg;

    typedef enum logic [1:0] {
        RES_DONE  = 2'b00,
        RES_UNDEF = 2'b01,
        RES_TRAP  = 2'b10
    } res_e;

    localparam int unsigned LVL_W = 2;
    localparam int unsigned SYN_W = 6;

    localparam logic [LVL_W-1:0] LVL_USER = 2'd0;
    localparam logic [LVL_W-1:0] LVL_OS   = 2'd1;
    localparam logic [LVL_W-1:0] LVL_HYP  = 2'd2;
    localparam logic [LVL_W-1:0] LVL_MON  = 2'd3;

    localparam logic [SYN_W-1:0] SYN_SYSREG = 6'h18;

endpackage

// File: rtl/brsrc_decide.sv
// Module: brsrc_decide
// Purely combinational priority chain that classifies one request as
// completed, undefined or trapped (with target level and syndrome).
// Assumes the inputs are stable while req_vld is high; outputs are zero
// / "completed" when no request is presented.
module brsrc_decide
    import brsrc_pkg::*;
(
    input  logic             req_vld,
    input  logic             req_wr,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             lvl3_present,
    input  logic             lvl2_enabled,
    input  logic             non_secure,
    input  logic [1:0]       sdbg_en,
    input  logic             fgt_present,
    input  logic             fgt_lvl3_en,
    input  logic             fgt_rd_n,
    input  logic             fgt_wr_n,
    input  logic             undef_first,
    input  logic             undef_sel,
    output res_e             res,
    output logic [LVL_W-1:0] tgt_lvl,
    output logic [SYN_W-1:0] syn
);

    logic field_blocked;
    logic fgt_hit;

    // Enable-field blocking for the current security state (needs level 3).
    always_comb begin
        if (non_secure)
            field_blocked = lvl3_present && !sdbg_en[0];
        else
            field_blocked = lvl3_present && (sdbg_en != 2'b11);
    end

    // Fine-grained trap condition; the direction picks the control bit.
    always_comb begin
        fgt_hit = lvl2_enabled && fgt_present
               && (!lvl3_present || fgt_lvl3_en)
               && !(req_wr ? fgt_wr_n : fgt_rd_n);
    end

    // Fixed-priority chain producing the outcome of the request.
    always_comb begin
        res     = RES_DONE;
        tgt_lvl = '0;
        if (req_vld) begin
            unique case (cur_lvl)
                LVL_USER: res = RES_UNDEF;
                LVL_MON:  res = RES_DONE;
                default: begin
                    if (field_blocked && undef_first) begin
                        res = RES_UNDEF;
                    end else if ((cur_lvl == LVL_OS) && fgt_hit) begin
                        res     = RES_TRAP;
                        tgt_lvl = LVL_HYP;
                    end else if (field_blocked) begin
                        if (undef_sel) begin
                            res = RES_UNDEF;
                        end else begin
                            res     = RES_TRAP;
                            tgt_lvl = LVL_MON;
                        end
                    end
                end
            endcase
        end
    end

    // Syndrome accompanies every trap and is zero otherwise.
    always_comb begin
        syn = (res == RES_TRAP) ? SYN_SYSREG : '0;
    end

endmodule

// File: rtl/brsrc_canon.sv
// Module: brsrc_canon
// Combinational canonicaliser for write data. When bits [DW-1:P] are
// uniform the word passes unchanged; otherwise the upper field becomes
// a top-bit-set, rest-clear pattern. Assumes 2 <= P <= DW-2.
module brsrc_canon #(
    parameter int unsigned DW = 64,
    parameter int unsigned P  = 56
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int unsigned UW = DW - P;
    localparam logic [UW-1:0] NONCANON = {1'b1, {(UW-1){1'b0}}};

    logic [UW-1:0] upper;
    logic          uniform;

    // Split off the upper field and test it for all-zeros or all-ones.
    always_comb begin
        upper   = din[DW-1:P];
        uniform = (&upper) || (~|upper);
    end

    // Keep the low bits; substitute the fixed pattern when not uniform.
    always_comb begin
        dout = uniform ? din : {NONCANON, din[P-1:0]};
    end

endmodule

// File: rtl/brsrc_store.sv
// Module: brsrc_store
// The address register itself: synchronous active-low reset to zero,
// loads only when the load strobe is high.
module brsrc_store #(
    parameter int unsigned DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);

    // Hold the injected address; clear on reset, update on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end

endmodule

// File: rtl/brsrc_gate.sv
// Module: brsrc_gate (top)
// Branch-record source address register behind a privilege access gate.
// The outcome is combinational on the request; a completed write loads the
// canonicalised data at the next rising edge; rd_data always shows the
// register. Assumes one request per cycle and a 2-bit enable field.
module brsrc_gate
    import brsrc_pkg::*;
#(
    parameter int unsigned DW = 64,
    parameter int unsigned P  = 56
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_vld,
    input  logic          req_wr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    cur_lvl,
    input  logic          lvl3_present,
    input  logic          lvl2_enabled,
    input  logic          non_secure,
    input  logic [1:0]    sdbg_en,
    input  logic          fgt_present,
    input  logic          fgt_lvl3_en,
    input  logic          fgt_rd_n,
    input  logic          fgt_wr_n,
    input  logic          undef_first,
    input  logic          undef_sel,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    result,
    output logic [1:0]    trap_lvl,
    output logic [5:0]    syndrome
);

    res_e          res;
    logic [DW-1:0] canon_data;
    logic          wr_load;

    brsrc_decide u_decide (
        .req_vld      (req_vld),
        .req_wr       (req_wr),
        .cur_lvl      (cur_lvl),
        .lvl3_present (lvl3_present),
        .lvl2_enabled (lvl2_enabled),
        .non_secure   (non_secure),
        .sdbg_en      (sdbg_en),
        .fgt_present  (fgt_present),
        .fgt_lvl3_en  (fgt_lvl3_en),
        .fgt_rd_n     (fgt_rd_n),
        .fgt_wr_n     (fgt_wr_n),
        .undef_first  (undef_first),
        .undef_sel    (undef_sel),
        .res          (res),
        .tgt_lvl      (trap_lvl),
        .syn          (syndrome)
    );

    brsrc_canon #(.DW(DW), .P(P)) u_canon (
        .din  (req_wdata),
        .dout (canon_data)
    );

    // Load the register only for a write request that completes.
    always_comb begin
        wr_load = req_vld && req_wr && (res == RES_DONE);
        result  = res;
    end

    brsrc_store #(.DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_load),
        .din   (canon_data),
        .q     (rd_data)
    );

endmodule

// File: rtl/brsrc_gate_chk.sv
// Module: brsrc_gate_chk
// Port-level assertion checker for brsrc_gate, attached by bind below.
module brsrc_gate_chk #(
    parameter int unsigned DW = 64,
    parameter int unsigned P  = 56
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_vld,
    input logic          req_wr,
    input logic [DW-1:0] req_wdata,
    input logic [1:0]    cur_lvl,
    input logic          lvl3_present,
    input logic          lvl2_enabled,
    input logic          non_secure,
    input logic [1:0]    sdbg_en,
    input logic          fgt_present,
    input logic          fgt_lvl3_en,
    input logic          fgt_rd_n,
    input logic          fgt_wr_n,
    input logic          undef_first,
    input logic          undef_sel,
    input logic [DW-1:0] rd_data,
    input logic [1:0]    result,
    input logic [1:0]    trap_lvl,
    input logic [5:0]    syndrome
);

    localparam int unsigned UW = DW - P;

    logic blk;
    logic mixed;
    always_comb begin
        blk   = lvl3_present && (non_secure ? !sdbg_en[0] : (sdbg_en != 2'b11));
        mixed = !((&req_wdata[DW-1:P]) || (~|req_wdata[DW-1:P]));
    end

    // R1
    lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_lvl == 2'd0) |-> result == 2'b01);

    // R2
    lvl3_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_lvl == 2'd3) |-> result == 2'b00);

    // R3
    early_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_lvl[1] != cur_lvl[0] && undef_first && blk) |-> result == 2'b01);

    // R5
    hyp_no_self_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_lvl == 2'd2) |-> trap_lvl != 2'd2);

    // R7
    trap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result == 2'b10) |-> (syndrome == 6'h18 && trap_lvl[1]));

    // R7
    idle_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result != 2'b10) |-> (syndrome == 6'h0 && trap_lvl == 2'd0 && result != 2'b11));

    // R10
    noncanon_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_wr && result == 2'b00 && mixed)
        |=> rd_data[DW-1:P] == {1'b1, {(UW-1){1'b0}}});

    // R11
    blocked_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_wr && result != 2'b00) |=> $stable(rd_data));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_vld) |=> $stable(rd_data));

endmodule

bind brsrc_gate brsrc_gate_chk #(.DW(DW), .P(P)) u_chk (.*);

// File: tb/brsrc_gate_tb.sv
// Bench for brsrc_gate: a vector table for the access chain, then
// directed tests for reset, canonicalisation and blocked writes.
module brsrc_gate_tb;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DW = 64;
    localparam int unsigned P  = 56;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_vld = 1'b0, req_wr = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    cur_lvl = '0;
    logic          lvl3_present = 1'b1, lvl2_enabled = 1'b1, non_secure = 1'b1;
    logic [1:0]    sdbg_en = 2'b11;
    logic          fgt_present = 1'b1, fgt_lvl3_en = 1'b1;
    logic          fgt_rd_n = 1'b1, fgt_wr_n = 1'b1;
    logic          undef_first = 1'b0, undef_sel = 1'b0;
    logic [DW-1:0] rd_data;
    logic [1:0]    result, trap_lvl;
    logic [5:0]    syndrome;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brsrc_gate #(.DW(DW), .P(P)) u_dut (.*);

    typedef struct packed {
        logic [1:0] lvl;
        logic       wr, l3, ns;
        logic [1:0] en;
        logic       l2e, fgi, fge3, rdn, wrn, pri, sel;
        logic [1:0] res, tl;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VT [NV] = '{
        // R1: level 0 read / write
        '{2'd0,1'b0,1'b1,1'b1,2'b11,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,2'b01,2'd0,4'd1},
        '{2'd0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,2'b01,2'd0,4'd1},
        // R2: level 3 ignores blocking and trap bits
        '{2'd3,1'b0,1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,2'd0,4'd2},
        '{2'd3,1'b1,1'b1,1'b1,2'b11,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'd0,4'd2},
        // R3: early undefined, secure and non-secure
        '{2'd1,1'b0,1'b1,1'b0,2'b10,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,2'b01,2'd0,4'd3},
        '{2'd2,1'b1,1'b1,1'b1,2'b10,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,2'b01,2'd0,4'd3},
        // R4: fine-grained trap to level 2
        '{2'd1,1'b0,1'b1,1'b1,2'b01,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,2'b10,2'd2,4'd4},
        '{2'd1,1'b0,1'b0,1'b0,2'b00,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'b10,2'd2,4'd4},
        '{2'd1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,2'd0,4'd4},
        '{2'd1,1'b0,1'b1,1'b1,2'b11,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'd0,4'd4},
        // R5: level 2 ignores fine-grained bits
        '{2'd2,1'b0,1'b1,1'b1,2'b11,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'd0,4'd5},
        // R8: direction picks the trap bit
        '{2'd1,1'b1,1'b1,1'b1,2'b11,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'd0,4'd8},
        '{2'd1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'd0,4'd8},
        '{2'd1,1'b1,1'b1,1'b1,2'b11,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b10,2'd2,4'd8},
        // R6: late blocked handling
        '{2'd1,1'b0,1'b1,1'b0,2'b01,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,2'b10,2'd3,4'd6},
        '{2'd2,1'b1,1'b1,1'b1,2'b10,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,2'b01,2'd0,4'd6},
        '{2'd2,1'b1,1'b1,1'b0,2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,2'b10,2'd3,4'd6},
        // R4: fine-grained trap outranks late blocked handling
        '{2'd1,1'b0,1'b1,1'b0,2'b10,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,2'b10,2'd2,4'd4},
        // R3: early undefined outranks fine-grained trap
        '{2'd1,1'b0,1'b1,1'b0,2'b10,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,2'd0,4'd3},
        // R3: no level 3 -> never blocked
        '{2'd2,1'b0,1'b0,1'b0,2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,2'd0,4'd3},
        // R4: fine-grained traps not implemented
        '{2'd1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'd0,4'd4}
    };

    task automatic check64(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_clean();
        lvl3_present = 1'b1; lvl2_enabled = 1'b1; non_secure = 1'b1; sdbg_en = 2'b11;
        fgt_present = 1'b1; fgt_lvl3_en = 1'b1; fgt_rd_n = 1'b1; fgt_wr_n = 1'b1;
        undef_first = 1'b0; undef_sel = 1'b0;
    endtask

    // One request: drive at negedge, leave it across the next rising edge.
    task automatic access(input logic [1:0] lvl, input logic wr, input logic [DW-1:0] d);
        @(negedge clk);
        cur_lvl = lvl; req_wr = wr; req_wdata = d; req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0; req_wr = 1'b0;
    endtask

    function automatic logic [DW-1:0] canon(input logic [DW-1:0] d);
        logic [DW-P-1:0] up = d[DW-1:P];
        if ((&up) || (~|up)) return d;
        return {1'b1, {(DW-P-1){1'b0}}, d[P-1:0]};
    endfunction

    initial begin
        logic [DW-1:0] held;
        // Watchdog: a hung run counts as a failure and still reports.
        fork
            begin
                #(CLK_PERIOD * 20000);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R11 reset value", rd_data, '0);
        check64("R7 idle result", {62'd0, result}, 64'd0);

        // Table walk over the access chain (R1..R8).
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cur_lvl = VT[i].lvl; req_wr = VT[i].wr; req_wdata = '0;
            lvl3_present = VT[i].l3; non_secure = VT[i].ns; sdbg_en = VT[i].en;
            lvl2_enabled = VT[i].l2e; fgt_present = VT[i].fgi; fgt_lvl3_en = VT[i].fge3;
            fgt_rd_n = VT[i].rdn; fgt_wr_n = VT[i].wrn;
            undef_first = VT[i].pri; undef_sel = VT[i].sel;
            req_vld = 1'b1;
            #1;
            check64($sformatf("R%0d vector %0d result", VT[i].rq, i), {62'd0, result}, {62'd0, VT[i].res});
            check64($sformatf("R7 vector %0d trap level", i), {62'd0, trap_lvl}, {62'd0, VT[i].tl});
            check64($sformatf("R7 vector %0d syndrome", i), {58'd0, syndrome},
                    (VT[i].res == 2'b10) ? 64'h18 : 64'h0);
        end
        @(negedge clk);
        req_vld = 1'b0; req_wr = 1'b0;
        set_clean();

        // R9 / R12: canonical low address stored and visible after the edge.
        access(2'd3, 1'b1, 64'h0000_1234_5678_9ABC);
        check64("R9 R12 canonical zero-upper", rd_data, 64'h0000_1234_5678_9ABC);
        // R9: sign-extended negative address
        access(2'd1, 1'b1, 64'hFF80_0000_0000_0001);
        check64("R9 canonical ones-upper", rd_data, 64'hFF80_0000_0000_0001);
        // R10: mixed upper fields
        access(2'd3, 1'b1, 64'h1234_5678_9ABC_DEF0);
        check64("R10 mixed upper 12", rd_data, canon(64'h1234_5678_9ABC_DEF0));
        check64("R10 pattern value", rd_data, 64'h8034_5678_9ABC_DEF0);
        access(2'd2, 1'b1, 64'h7F00_0000_0000_0005);
        check64("R10 mixed upper 7F", rd_data, 64'h8000_0000_0000_0005);

        // R11: undefined and trapped writes leave the register alone.
        held = rd_data;
        access(2'd0, 1'b1, 64'hDEAD_BEEF_0000_0000);
        check64("R11 undefined write held", rd_data, held);
        fgt_wr_n = 1'b0;
        access(2'd1, 1'b1, 64'h0000_0000_CAFE_F00D);
        check64("R11 trapped write held", rd_data, held);
        set_clean();
        non_secure = 1'b0; sdbg_en = 2'b00;
        access(2'd2, 1'b1, 64'h0000_0000_0000_0042);
        check64("R11 level-3 trapped write held", rd_data, held);
        set_clean();
        // R12: a read does not disturb the register
        access(2'd1, 1'b0, 64'h0000_0000_0000_0099);
        check64("R12 read leaves value", rd_data, held);

        // R11: synchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check64("R11 reset clears", rd_data, '0);
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule